// File: doc/BRIEF.md
# Two-Lane Fast FIR Filter

This block is a finite-impulse-response filter that accepts two samples of one stream in each clock cycle: the even-indexed sample x(2n) on one lane and the odd-indexed sample x(2n+1) on the other. In the cycle after it accepts a pair, it returns the two matching outputs y(2n) and y(2n+1). The coefficient set of even length N is fixed by a parameter. Results are identical, sample for sample, to a serial direct-form filter run on the interleaved stream.

The coefficients are split into an even-indexed half-filter and an odd-indexed half-filter. A third half-filter runs on a pre-combined lane and uses pre-combined coefficients. The even-half product and the odd-half product are each formed once and shared by both outputs, so the block needs three sub-filters of N/2 taps instead of four. That is 3N/2 multipliers against 2N. A parameter selects the combining form. The sum form pairs (H0+H1) with (X0+X1) and subtracts both shared products. The difference form pairs (H0−H1) with (X0−X1) and subtracts that product from the sum of the shared products.

Blocks may arrive with idle cycles between them. The filter history advances only on accepted blocks.

Top module: `fastFirPair`

## Requirements
- R1: After each accepted block n, outEven equals sum over k of c[k]·x(2n−k), where samples before reset count as zero. Coefficient k sits at bits [k·COEF_W +: COEF_W] of COEF_VEC.
- R2: With ALT_FORM=0 (sum form), outOdd equals sum over k of c[k]·x(2n+1−k).
- R3: With ALT_FORM=1 (difference form), both outputs equal the values that R1 and R2 require, for every input sequence.
- R4: A sample on the odd lane of block n contributes to outEven of block n+1 and later blocks through the odd-indexed coefficients. This cross-block term survives idle cycles between blocks.
- R5: outValid is high exactly in the cycle after a cycle with inValid high. The new outputs are present in that cycle.
- R6: While inValid is low, the inputs are ignored and outEven, outOdd and the filter history hold their values.
- R7: After N/2+1 consecutive accepted blocks of all-zero samples, both outputs are zero.
- R8: Reset clears the outputs, outValid and all history. The first block after reset is filtered as if all earlier samples were zero.
- R9: Full-scale negative samples and coefficients produce exact results without overflow. The output width is DATA_W+COEF_W+clog2(N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A sample pair is present on the input lanes |
| inEven | input | DATA_W | Signed sample x(2n) |
| inOdd | input | DATA_W | Signed sample x(2n+1) |
| outValid | output | 1 | Output pair updated in this cycle |
| outEven | output | DATA_W+COEF_W+clog2(NUM_TAPS) | Signed output y(2n) |
| outOdd | output | DATA_W+COEF_W+clog2(NUM_TAPS) | Signed output y(2n+1) |

## Verification
On every cycle, the assertions check four things:
- the one-cycle lag from accepted input to outValid;
- that both outputs are frozen across idle cycles;
- that both outputs are zero before the first block and after a long enough run of zero blocks;
- that the internal sums never carry significant bits above the output width.

Only the bench scenarios can show the arithmetic itself. They cover the even and odd coefficient split, the cross-block delay of the odd-half term, and the equivalence of the sum and difference forms. The bench checks these by running both forms side by side against a serial direct-form model, using impulses, full-scale negative inputs and random streams with idle gaps.

// File: rtl/fir2Pkg.sv
package fir2Pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // advance all delay lines and the cross-block register
    logic outLoad;  // capture the new output pair
  } fir2Strobe_t;
endpackage

// File: rtl/fir2SubFilter.sv
module fir2SubFilter #(
  parameter int TAPS = 4,
  parameter int IN_W = 13,
  parameter int CF_W = 13,
  parameter int ACC_W = 29,
  parameter logic [TAPS*CF_W-1:0] COEF_VEC = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    shiftEn,
  input  logic signed [IN_W-1:0]  sampleIn,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [IN_W-1:0] tapVal [TAPS];

  assign tapVal[0] = sampleIn;

  generate
    if (TAPS > 1) begin : gLine
      logic signed [IN_W-1:0] hist [TAPS-1];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < TAPS-1; i++) hist[i] <= '0;
        end else if (shiftEn) begin
          hist[0] <= sampleIn;
          for (int i = 1; i < TAPS-1; i++) hist[i] <= hist[i-1];
        end
      end
      for (genvar t = 1; t < TAPS; t++) begin : gTap
        assign tapVal[t] = hist[t-1];
      end
    end
  endgenerate

  always_comb begin
    logic signed [ACC_W-1:0] sum;
    sum = '0;
    for (int m = 0; m < TAPS; m++) begin
      sum = sum + ACC_W'(tapVal[m]) * ACC_W'(signed'(COEF_VEC[m*CF_W +: CF_W]));
    end
    acc = sum;
  end
endmodule

// File: rtl/fir2Ctrl.sv
module fir2Ctrl
  import fir2Pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output fir2Strobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.shiftEn = inValid;
    strobe.outLoad = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R5
  AST_NO_EXTRA_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R5
endmodule

// File: rtl/fir2Datapath.sv
module fir2Datapath
  import fir2Pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int NUM_TAPS = 8,
  parameter bit ALT_FORM = 1'b0,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fir2Strobe_t             strobe,
  input  logic signed [DATA_W-1:0] xEven,
  input  logic signed [DATA_W-1:0] xOdd,
  output logic signed [DATA_W+COEF_W+$clog2(NUM_TAPS)-1:0] yEven,
  output logic signed [DATA_W+COEF_W+$clog2(NUM_TAPS)-1:0] yOdd
);
  localparam int HALF   = NUM_TAPS / 2;
  localparam int LANE_W = DATA_W + 1;
  localparam int SUB_CW = COEF_W + 1;
  localparam int OUT_W  = DATA_W + COEF_W + $clog2(NUM_TAPS);
  localparam int INT_W  = OUT_W + 2;
  localparam int RUN_W  = $clog2(HALF + 2);

  // which: 0 even-indexed half, 1 odd-indexed half, 2 combined half
  function automatic logic [HALF*SUB_CW-1:0] splitCoefs(input int which);
    logic [HALF*SUB_CW-1:0] r;
    logic signed [SUB_CW-1:0] a, b;
    r = '0;
    for (int m = 0; m < HALF; m++) begin
      a = SUB_CW'(signed'(COEF_VEC[(2*m)*COEF_W +: COEF_W]));
      b = SUB_CW'(signed'(COEF_VEC[(2*m+1)*COEF_W +: COEF_W]));
      if (which == 0)      r[m*SUB_CW +: SUB_CW] = a;
      else if (which == 1) r[m*SUB_CW +: SUB_CW] = b;
      else if (ALT_FORM)   r[m*SUB_CW +: SUB_CW] = a - b;
      else                 r[m*SUB_CW +: SUB_CW] = a + b;
    end
    return r;
  endfunction

  logic signed [LANE_W-1:0] lane [3];
  logic signed [INT_W-1:0]  part [3];
  logic signed [INT_W-1:0]  oddPrev;
  logic signed [INT_W-1:0]  yEvenNext, yOddNext;
  logic signed [LANE_W-1:0] evenExt, oddExt;

  // Pre-combination of the two lanes
  always_comb begin
    evenExt = LANE_W'(xEven);
    oddExt  = LANE_W'(xOdd);
    lane[0] = evenExt;
    lane[1] = oddExt;
    lane[2] = ALT_FORM ? (evenExt - oddExt) : (evenExt + oddExt);
  end

  generate
    for (genvar g = 0; g < 3; g++) begin : gSub
      fir2SubFilter #(
        .TAPS(HALF), .IN_W(LANE_W), .CF_W(SUB_CW), .ACC_W(INT_W),
        .COEF_VEC(splitCoefs(g))
      ) subFilter_i (
        .clk(clk), .rstN(rstN), .shiftEn(strobe.shiftEn),
        .sampleIn(lane[g]), .acc(part[g])
      );
    end
  endgenerate

  // Cross-block delay of the odd-half product
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               oddPrev <= '0;
    else if (strobe.shiftEn) oddPrev <= part[1];
  end

  // Post-combination
  always_comb begin
    yEvenNext = part[0] + oddPrev;
    if (ALT_FORM) yOddNext = part[0] + part[1] - part[2];
    else          yOddNext = part[2] - part[0] - part[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yEven <= '0;
      yOdd  <= '0;
    end else if (strobe.outLoad) begin
      yEven <= yEvenNext[OUT_W-1:0];
      yOdd  <= yOddNext[OUT_W-1:0];
    end
  end

  // Checker state: zero-block run length and first-block flag
  logic [RUN_W-1:0] zeroRun;
  logic             seenBlock;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun   <= '0;
      seenBlock <= 1'b0;
    end else if (strobe.shiftEn) begin
      seenBlock <= 1'b1;
      if (xEven != '0 || xOdd != '0) zeroRun <= '0;
      else if (zeroRun <= RUN_W'(HALF)) zeroRun <= zeroRun + 1'b1;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(yEven) && $stable(yOdd));  // R6
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (zeroRun > RUN_W'(HALF)) |-> (yEven == '0 && yOdd == '0));  // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !seenBlock |-> (yEven == '0 && yOdd == '0));  // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outLoad |->
      ((&yEvenNext[INT_W-1:OUT_W-1]) || !(|yEvenNext[INT_W-1:OUT_W-1])) &&
      ((&yOddNext[INT_W-1:OUT_W-1])  || !(|yOddNext[INT_W-1:OUT_W-1])));  // R9
endmodule

// File: rtl/fastFirPair.sv
module fastFirPair
  import fir2Pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int NUM_TAPS = 8,
  parameter bit ALT_FORM = 1'b0,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = {
    12'sd3, -12'sd20, 12'sd90, 12'sd400, 12'sd400, 12'sd90, -12'sd20, 12'sd3}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inEven,
  input  logic signed [DATA_W-1:0] inOdd,
  output logic                     outValid,
  output logic signed [DATA_W+COEF_W+$clog2(NUM_TAPS)-1:0] outEven,
  output logic signed [DATA_W+COEF_W+$clog2(NUM_TAPS)-1:0] outOdd
);
  fir2Strobe_t strobe;

  fir2Ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  fir2Datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NUM_TAPS(NUM_TAPS),
    .ALT_FORM(ALT_FORM), .COEF_VEC(COEF_VEC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xEven(inEven), .xOdd(inOdd),
    .yEven(outEven), .yOdd(outOdd)
  );
endmodule

// File: tb/fastFirPair_tb_top.sv
module fastFirPair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int CW = 12;
  localparam int NT = 8;
  localparam int OW = DW + CW + $clog2(NT);
  localparam logic [NT*CW-1:0] CV = {
    12'sd129, -12'sd7, 12'sd0, 12'sd1000, -12'sd300, 12'sd5, 12'sd2047, -12'sd2048};

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic signed [DW-1:0] inEven, inOdd;
  logic outValidS, outValidD;
  logic signed [OW-1:0] evenS, oddS, evenD, oddD;

  always #(CLK_PERIOD/2) clk = ~clk;

  fastFirPair #(.DATA_W(DW), .COEF_W(CW), .NUM_TAPS(NT), .ALT_FORM(1'b0), .COEF_VEC(CV)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEven(inEven), .inOdd(inOdd),
    .outValid(outValidS), .outEven(evenS), .outOdd(oddS));

  fastFirPair #(.DATA_W(DW), .COEF_W(CW), .NUM_TAPS(NT), .ALT_FORM(1'b1), .COEF_VEC(CV)) dutAlt_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEven(inEven), .inOdd(inOdd),
    .outValid(outValidD), .outEven(evenD), .outOdd(oddD));

  int cf [NT] = '{-2048, 2047, 5, -300, 1000, 0, -7, 129};
  longint sx [0:4095];
  int sCnt = 0;
  int checks = 0;
  int failures = 0;

  function automatic longint refOut(int idx);
    longint s = 0;
    for (int k = 0; k < NT; k++)
      if (idx - k >= 0) s += longint'(cf[k]) * sx[idx-k];
    return s;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; checks at the next falling edge
  task automatic sendBlock(longint e, longint o, string tagE, string tagO);
    inValid = 1'b1;
    inEven = DW'(e);
    inOdd  = DW'(o);
    sx[sCnt] = e;
    sx[sCnt+1] = o;
    sCnt += 2;
    @(negedge clk);
    chk("R5", "outValid sum form", longint'(outValidS), 1);
    chk("R5", "outValid diff form", longint'(outValidD), 1);
    chk(tagE, "even sum form", longint'(evenS), refOut(sCnt-2));
    chk(tagO, "odd sum form", longint'(oddS), refOut(sCnt-1));
    chk("R3", "even diff form", longint'(evenD), refOut(sCnt-2));
    chk("R3", "odd diff form", longint'(oddD), refOut(sCnt-1));
  endtask

  task automatic idleCycle();
    longint pe, po;
    pe = longint'(evenS);
    po = longint'(oddD);
    inValid = 1'b0;
    inEven = DW'($urandom);
    inOdd  = DW'($urandom);
    @(negedge clk);
    chk("R5", "outValid idle", longint'(outValidS), 0);
    chk("R6", "even held", longint'(evenS), pe);
    chk("R6", "odd held", longint'(oddD), po);
  endtask

  task automatic sendRandom(string tagE, string tagO);
    logic signed [DW-1:0] a, b;
    a = DW'($urandom);
    b = DW'($urandom);
    sendBlock(longint'(a), longint'(b), tagE, tagO);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rstN = 1'b0;
    inValid = 1'b0;
    inEven = '0;
    inOdd = '0;
    repeat (2) @(negedge clk);
    chk("R8", "outValid in reset", longint'(outValidS), 0);
    chk("R8", "even in reset", longint'(evenS), 0);
    chk("R8", "odd in reset", longint'(oddD), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Impulse on the even lane exposes each coefficient
    sendBlock(1, 0, "R1", "R2");
    for (int i = 0; i < 4; i++) sendBlock(0, 0, "R1", "R2");
    // Impulse on the odd lane: cross-block term, with idle gaps
    sendBlock(0, 1, "R4", "R4");
    idleCycle();
    sendBlock(0, 0, "R4", "R4");
    idleCycle();
    idleCycle();
    for (int i = 0; i < 4; i++) sendBlock(0, 0, "R4", "R4");
    // Full-scale negative samples
    for (int i = 0; i < 5; i++) sendBlock(-2048, -2048, "R9", "R9");
    sendBlock(2047, -2048, "R9", "R9");
    sendBlock(-2048, 2047, "R9", "R9");
    // Flush with zero blocks
    for (int i = 0; i < 5; i++) sendBlock(0, 0, "R7", "R7");
    chk("R7", "even after flush", longint'(evenS), 0);
    chk("R7", "odd after flush", longint'(oddD), 0);
    // Random stream with idle gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idleCycle();
      sendRandom("R1", "R2");
    end
    // Reset in mid-stream clears history
    rstN = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    chk("R8", "outValid after mid reset", longint'(outValidS), 0);
    chk("R8", "even after mid reset", longint'(evenS), 0);
    rstN = 1'b1;
    sCnt = 0;
    @(negedge clk);
    sendBlock(3, -5, "R8", "R8");
    for (int i = 0; i < 20; i++) sendRandom("R1", "R2");
    inValid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule